// File: doc/BRIEF.md
# DMA Single-Address Configuration Validator

This block screens the settings of one DMA channel at the moment a single-address transfer is launched. It decides, before any bus cycle is issued, whether the programmed combination of direction, mode, size, source address, source step and byte count is legal. A launch strobe presents the settings. One clock later the block either emits a one-cycle grant that lets the transfer engine proceed, or it sets a sticky configuration-fault bit and withholds the grant.

Legality covers three things. The first is the source step: a zero step is allowed only when moving memory to external I/O, and burst mode accepts only a step of +8, 0 or -8. The second is the low bits of the source address, whose required pattern depends on the sign of the step. The third is the granularity of the byte count. The destination address and destination step are present on the interface, because the channel register file carries them, but in single-address mode they never influence the outcome.

Top module: `dmasa_cfg_check`

## Requirements
- R1: The size code `size_i` maps 0..7 to 1, 2, 4, 8 bytes, then 4, 8, 16, 32 double words. The alignment granularity is the size capped at 8 bytes, so codes 3 to 7 all demand 3 low bits and code 0 demands none.
- R2: A source step of zero faults when `dir_i`=1 (I/O to memory) or `fill_i`=1 (memory fill). With `dir_i`=0 and `fill_i`=0 it is legal.
- R3: With `burst_i`=1 the source step must equal +8, 0 or -8, and any other value faults. With `burst_i`=0 any step value passes this rule.
- R4: With a negative step, the low source bits covered by the granularity must all be 1: bit 0 for 2 bytes, bits [1:0] for 4 bytes, bits [2:0] for 8 bytes or more.
- R5: With a zero or positive step, the same low source bits must all be 0 (natural alignment up to 8 bytes).
- R6: The low bits of `count_lo_i` covered by the granularity must be 0, otherwise the settings fault.
- R7: A launch whose settings pass every rule produces `grant_o`=1 for exactly the one cycle after the launch edge. A launch that breaks any rule sets `err_o` in that same cycle. `grant_o` and `err_o` are never high together.
- R8: `err_o` stays set until `err_clr_i` is 1 at a clock edge. While `err_o` is set, launches are ignored: no grant, no change.
- R9: `dst_addr_i` and `dst_step_i` have no effect on `grant_o` or `err_o`.
- R10: After synchronous reset, `grant_o`=0 and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch strobe, one cycle |
| dir_i | input | 1 | 0 memory to I/O, 1 I/O to memory |
| burst_i | input | 1 | 1 burst mode, 0 single mode |
| fill_i | input | 1 | 1 memory-fill transfer |
| size_i | input | 3 | Transfer size code |
| src_lo_i | input | 3 | Source address bits [2:0] |
| src_step_i | input | STEP_W | Signed source address step |
| count_lo_i | input | 3 | Byte count bits [2:0] |
| dst_addr_i | input | ADDR_W | Destination address (ignored) |
| dst_step_i | input | STEP_W | Destination step (ignored) |
| err_clr_i | input | 1 | Write-one-to-clear for the fault bit |
| grant_o | output | 1 | One-cycle transfer grant |
| err_o | output | 1 | Sticky configuration fault |

## Verification
Random launches draw steps from zero, plus or minus eight, small odd values and large values of both signs. This separates the zero-step rule from the burst-set rule, and both from the sign-dependent address rule. Source bits are biased half the time toward the pattern the sign demands, so that count-granularity faults show up on their own and are not masked by address faults. Directed cases pin the remaining corners. Size codes above 3 must behave as 8-byte granularity. A zero step must pass memory-to-I/O but fail in fill mode. Launches while the fault is set must be ignored. Two launches that differ only in destination settings must give the same result.

// File: rtl/dmasa_pkg.sv
package dmasa_pkg;

    localparam int LOW_W = 3;

    typedef enum logic [2:0] {
        SZ_B1   = 3'd0,
        SZ_B2   = 3'd1,
        SZ_B4   = 3'd2,
        SZ_B8   = 3'd3,
        SZ_DW4  = 3'd4,
        SZ_DW8  = 3'd5,
        SZ_DW16 = 3'd6,
        SZ_DW32 = 3'd7
    } xfer_size_e;

    typedef enum logic {
        DIR_MEM_TO_IO = 1'b0,
        DIR_IO_TO_MEM = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic step_zero;
        logic step_burst;
        logic src_align;
        logic cnt_align;
    } fault_t;

    // bytes moved per element for each size code
    function automatic int unsigned size_bytes(input xfer_size_e sz);
        int unsigned b;
        if (sz <= SZ_B8) b = 32'd1 << sz;
        else             b = 32'd8 << (sz - SZ_DW4 + 2);
        return b;
    endfunction

    // low-bit mask that must obey the alignment rules (granularity capped at 8 bytes)
    function automatic logic [LOW_W-1:0] gran_mask(input xfer_size_e sz);
        int unsigned g;
        g = size_bytes(sz);
        if (g > (32'd1 << LOW_W)) g = 32'd1 << LOW_W;
        return LOW_W'(g - 1);
    endfunction

endpackage

// File: rtl/dmasa_step_rule.sv
module dmasa_step_rule
    import dmasa_pkg::*;
#(
    parameter int STEP_W     = 16,
    parameter int BURST_STEP = 8
) (
    input  xfer_dir_e                 dir,
    input  logic                      burst,
    input  logic                      fill,
    input  logic signed [STEP_W-1:0]  step,
    output logic                      zero_fault,
    output logic                      burst_fault,
    output logic                      step_neg
);
    localparam logic signed [STEP_W-1:0] STEP_POS = STEP_W'(BURST_STEP);
    localparam logic signed [STEP_W-1:0] STEP_NEG = -STEP_W'(BURST_STEP);

    logic is_zero;
    logic in_burst_set;

    always_comb begin
        is_zero      = (step == '0);
        step_neg     = step[STEP_W-1];
        in_burst_set = is_zero || (step == STEP_POS) || (step == STEP_NEG);
        zero_fault   = is_zero && ((dir == DIR_IO_TO_MEM) || fill);
        burst_fault  = burst && !in_burst_set;
    end

endmodule

// File: rtl/dmasa_align_rule.sv
module dmasa_align_rule
    import dmasa_pkg::*;
(
    input  xfer_size_e       size,
    input  logic             step_neg,
    input  logic [LOW_W-1:0] src_lo,
    input  logic [LOW_W-1:0] cnt_lo,
    output logic             src_fault,
    output logic             cnt_fault
);
    logic [LOW_W-1:0] mask;
    logic [LOW_W-1:0] src_bad;
    logic [LOW_W-1:0] cnt_bad;

    assign mask = gran_mask(size);

    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        // a covered source bit must equal the step sign: ones going down, zeros going up
        assign src_bad[i] = mask[i] && (src_lo[i] != step_neg);
        assign cnt_bad[i] = mask[i] && cnt_lo[i];
    end

    assign src_fault = |src_bad;
    assign cnt_fault = |cnt_bad;

endmodule

// File: rtl/dmasa_status_reg.sv
module dmasa_status_reg (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cfg_ok,
    input  logic clr,
    output logic grant,
    output logic err
);
    logic accept;

    assign accept = start && !err;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= 1'b0;
            err   <= 1'b0;
        end else begin
            grant <= accept && cfg_ok;
            if (err && clr)
                err <= 1'b0;
            else if (accept && !cfg_ok)
                err <= 1'b1;
        end
    end

    p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        !(grant && err));

    p_grant_cause_r7: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(start) && !$past(err));

    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(start));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err && !clr |=> err);

    p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        err |=> !grant);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        err && clr |=> !err);

endmodule

// File: rtl/dmasa_cfg_check.sv
module dmasa_cfg_check
    import dmasa_pkg::*;
#(
    parameter int STEP_W     = 16,
    parameter int ADDR_W     = 32,
    parameter int BURST_STEP = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     dir_i,
    input  logic                     burst_i,
    input  logic                     fill_i,
    input  logic [2:0]               size_i,
    input  logic [2:0]               src_lo_i,
    input  logic signed [STEP_W-1:0] src_step_i,
    input  logic [2:0]               count_lo_i,
    input  logic [ADDR_W-1:0]        dst_addr_i,
    input  logic [STEP_W-1:0]        dst_step_i,
    input  logic                     err_clr_i,
    output logic                     grant_o,
    output logic                     err_o
);
    fault_t     fault;
    logic       step_neg;
    logic       cfg_ok;
    xfer_size_e size_e;
    xfer_dir_e  dir_e;

    // destination settings play no part in single-address checking
    logic unused_dst;
    assign unused_dst = ^{dst_addr_i, dst_step_i};

    assign size_e = xfer_size_e'(size_i);
    assign dir_e  = xfer_dir_e'(dir_i);

    dmasa_step_rule #(
        .STEP_W     (STEP_W),
        .BURST_STEP (BURST_STEP)
    ) u_step (
        .dir         (dir_e),
        .burst       (burst_i),
        .fill        (fill_i),
        .step        (src_step_i),
        .zero_fault  (fault.step_zero),
        .burst_fault (fault.step_burst),
        .step_neg    (step_neg)
    );

    dmasa_align_rule u_align (
        .size      (size_e),
        .step_neg  (step_neg),
        .src_lo    (src_lo_i),
        .cnt_lo    (count_lo_i),
        .src_fault (fault.src_align),
        .cnt_fault (fault.cnt_align)
    );

    assign cfg_ok = (fault == '0);

    dmasa_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .cfg_ok (cfg_ok),
        .clr    (err_clr_i),
        .grant  (grant_o),
        .err    (err_o)
    );

    p_zero_step_r2: assert property (@(posedge clk) disable iff (rst)
        start_i && !err_o && (src_step_i == '0) && (dir_i || fill_i) |=> err_o);

    p_burst_set_r3: assert property (@(posedge clk) disable iff (rst)
        start_i && !err_o && burst_i && (src_step_i != STEP_W'(BURST_STEP))
            && (src_step_i != -STEP_W'(BURST_STEP)) && (src_step_i != '0) |=> err_o);

    p_neg_half_r4: assert property (@(posedge clk) disable iff (rst)
        start_i && !err_o && src_step_i[STEP_W-1] && (size_i == 3'd1) && !src_lo_i[0] |=> err_o);

    p_pos_word_r5: assert property (@(posedge clk) disable iff (rst)
        start_i && !err_o && !src_step_i[STEP_W-1] && (size_i == 3'd2) && (src_lo_i[1:0] != 2'b00)
            |=> err_o);

endmodule

// File: tb/dmasa_cfg_check_tb_top.sv
module dmasa_cfg_check_tb_top;
    localparam int STEP_W = 16;
    localparam int ADDR_W = 32;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start_i = 1'b0;
    logic                     dir_i = 1'b0;
    logic                     burst_i = 1'b0;
    logic                     fill_i = 1'b0;
    logic [2:0]               size_i = '0;
    logic [2:0]               src_lo_i = '0;
    logic signed [STEP_W-1:0] src_step_i = '0;
    logic [2:0]               count_lo_i = '0;
    logic [ADDR_W-1:0]        dst_addr_i = '0;
    logic [STEP_W-1:0]        dst_step_i = '0;
    logic                     err_clr_i = 1'b0;
    logic                     grant_o;
    logic                     err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2ns clk = ~clk;

    dmasa_cfg_check #(.STEP_W(STEP_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .dir_i(dir_i), .burst_i(burst_i),
        .fill_i(fill_i), .size_i(size_i), .src_lo_i(src_lo_i), .src_step_i(src_step_i),
        .count_lo_i(count_lo_i), .dst_addr_i(dst_addr_i), .dst_step_i(dst_step_i),
        .err_clr_i(err_clr_i), .grant_o(grant_o), .err_o(err_o)
    );

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int gmask(input int sz);
        case (sz)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 7;
        endcase
    endfunction

    // "" when legal, else the requirement the settings break
    function automatic string ref_tag(input bit d, input bit b, input bit f, input int sz,
                                      input int src, input int step, input int cnt);
        int g;
        g = gmask(sz);
        if (step == 0 && (d || f)) return "R2";
        if (b && !(step == 8 || step == 0 || step == -8)) return "R3";
        if (step < 0 && (src & g) != g) return "R4";
        if (step >= 0 && (src & g) != 0) return "R5";
        if ((cnt & g) != 0) return "R6";
        return "";
    endfunction

    // launch once and check the outcome one cycle later; then clear any fault
    task automatic launch(input bit d, input bit b, input bit f, input int sz, input int src,
                          input int step, input int cnt, input string note);
        string t;
        bit ok;
        t  = ref_tag(d, b, f, sz, src, step, cnt);
        ok = (t == "");
        dir_i = d; burst_i = b; fill_i = f; size_i = 3'(sz); src_lo_i = 3'(src);
        src_step_i = STEP_W'(step); count_lo_i = 3'(cnt);
        dst_addr_i = $urandom; dst_step_i = 16'($urandom);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(grant_o == ok, ok ? {"R7 ", note} : {t, " ", note}, int'(grant_o), int'(ok));
        chk(err_o == !ok, ok ? {"R7 ", note} : {t, " ", note}, int'(err_o), int'(!ok));
        if (!ok) begin
            @(negedge clk);
            chk(err_o && !grant_o, "R8 hold", int'(err_o), 1);
            err_clr_i = 1'b1;
            @(negedge clk);
            err_clr_i = 1'b0;
            chk(!err_o, "R8 clear", int'(err_o), 0);
        end else begin
            @(negedge clk);
            chk(!grant_o, "R7 pulse width", int'(grant_o), 0);
        end
    endtask

    initial begin
        int src, step, r;
        void'($urandom(32'd4937));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!grant_o && !err_o, "R10 reset", int'({grant_o, err_o}), 0);
        @(negedge clk);

        // directed corners
        launch(0, 0, 0, 7, 4, 1, 0, "size 7 demands 3 bits (R1)");
        launch(0, 0, 0, 7, 0, 16, 0, "size 7 aligned (R1)");
        launch(0, 0, 0, 0, 5, 3, 7, "size 0 needs nothing (R1)");
        launch(0, 1, 0, 3, 0, 0, 0, "zero step mem to io");
        launch(0, 0, 1, 3, 0, 0, 0, "zero step fill");
        launch(1, 0, 0, 1, 0, 0, 0, "zero step io to mem");
        launch(0, 1, 0, 3, 7, -8, 0, "burst -8");
        launch(0, 1, 0, 3, 0, 16, 0, "burst +16");
        launch(0, 0, 0, 3, 0, 16, 0, "single +16");
        launch(0, 0, 0, 3, 7, -8, 0, "neg 0x7 example");
        launch(0, 0, 0, 2, 2, -4, 0, "neg word bad");
        launch(0, 0, 0, 1, 1, 2, 0, "pos half misaligned");
        launch(0, 0, 0, 2, 0, 4, 2, "count granularity");

        // R8: launches ignored while fault set
        launch(1, 0, 0, 0, 0, 0, 0, "set fault");
        dir_i = 1; size_i = 0; src_step_i = 0; start_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        chk(err_o, "R8 set for ignore test", int'(err_o), 1);
        dir_i = 0; src_step_i = 16'sd1; size_i = 0;
        @(negedge clk);
        start_i = 1'b0;
        chk(!grant_o && err_o, "R8 ignored launch", int'(grant_o), 0);
        err_clr_i = 1'b1;
        @(negedge clk);
        err_clr_i = 1'b0;
        chk(!err_o, "R8 clear after ignore", int'(err_o), 0);

        // R9: destination settings cannot change a result
        for (int k = 0; k < 2; k++) begin
            dir_i = 0; burst_i = 0; fill_i = 0; size_i = 3; src_lo_i = 0;
            src_step_i = 16'sd8; count_lo_i = 0;
            dst_addr_i = k ? '1 : '0; dst_step_i = k ? 16'h0003 : 16'h0000;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            chk(grant_o && !err_o, "R9 dst ignored", int'(grant_o), 1);
            @(negedge clk);
        end

        // random launches
        for (int n = 0; n < 400; n++) begin
            r = $urandom % 6;
            case (r)
                0: step = 0;
                1: step = 8;
                2: step = -8;
                3: step = int'($urandom % 15) - 7;
                4: step = int'($urandom % 20000);
                default: step = -int'($urandom % 20000) - 1;
            endcase
            src = ($urandom % 2) ? (step < 0 ? 7 : 0) : int'($urandom % 8);
            launch(bit'($urandom % 4 == 0), bit'($urandom % 2), bit'($urandom % 5 == 0),
                   int'($urandom % 8), src, step,
                   ($urandom % 2) ? 0 : int'($urandom % 8), "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule